// File: doc/BRIEF.md
# Coprocessor FIFO Mailbox

This block is the coprocessor side of a host's SRAM-style memory bus. The address bus picks one of several independent channels. Host writes push parameter words into that channel's input FIFO, and a processing engine drains those words. The engine works for as long as it needs and then returns result words into the channel's output FIFO. The host learns whether results are ready from a status word. It gets that status word as the first word of every read burst, so results are signalled in-band and no separate flag line is needed.

A read burst is a run of consecutive read-strobe cycles to the same address. The first word of the burst is the status word. If the channel holds a full result set, the next words of the burst are the result words, and reading them removes them from the FIFO. If no full result set is present, the rest of the burst reads as zero and the FIFO is left untouched. A host write to a full input FIFO is dropped, and the drop is recorded in a sticky per-channel overflow flag. The host can read these flags at the address just above the last channel. Each operation's parameter count and result count are fixed by agreement between host software and the engine. The block itself uses only the result count.

Top module: `copro_mailbox`

## Requirements
- R1: A write cycle to channel address p (0 to NP-1) with at least one byte-lane enable high pushes one word into channel p's input FIFO. Bits 8:0 come from the write data when lane bit 0 is set and are zero otherwise. Bits 17:9 come from the write data when lane bit 1 is set and are zero otherwise. The engine receives the words of each channel in write order.
- R2: The following writes change no FIFO and no flag: a write with both lane enables low, a write to the overflow address NP, and a write to an unmapped address above NP.
- R3: A write to a channel whose input FIFO is full is dropped and sets that channel's overflow flag. Flags are cleared only by reset. A read of address NP returns the flags in bits NP-1:0, with bit p belonging to channel p, and zeros above.
- R4: Word 0 of a read burst to a channel is the status word. Bit 0 is 1 exactly when the output FIFO holds at least RES_WORDS results at that cycle. All other bits are 0.
- R5: When the status word reads 0, every later word of the same burst reads 0 and no result is consumed.
- R6: When the status word reads 1, burst words 1 to RES_WORDS return the oldest results in order and remove them from the FIFO. Any further words of the burst read 0.
- R7: After a full result set has been read, the status bit of that channel is 0 unless another complete set has already arrived.
- R8: Read data and the read-valid output change one cycle after each read-strobe cycle. Read-valid is high exactly in the cycle after a read strobe, and read data is 0 whenever read-valid is low.
- R9: Reset empties every FIFO and clears every status bit and overflow flag.
- R10: The engine's parameter-available bit for a channel is high exactly when that channel's input FIFO is non-empty. The result-room bit is low exactly when that channel's output FIFO is full.
- R11: Channels are independent. Traffic on one channel never changes the data or status of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| hostAddr | input | PW | Channel select shared by reads and writes; NP selects the overflow flags |
| wrStrobeN | input | 1 | Write strobe, active low |
| byteEn | input | 2 | Lane enables for the write data (bit 0 covers the low half) |
| wrData | input | DW | Write data |
| rdStrobeN | input | 1 | Read strobe, active low |
| rdData | output | DW | Registered read data |
| rdValid | output | 1 | High in the cycle after a read strobe |
| engParamAvail | output | NP | Input FIFO non-empty, one bit per channel |
| engParamData | output | NP*DW | Head of each input FIFO |
| engParamPop | input | NP | Engine takes the head parameter word |
| engResultPush | input | NP | Engine delivers a result word |
| engResultData | input | NP*DW | Result words, one slice per channel |
| engResultRoom | output | NP | Output FIFO not full, one bit per channel |

## Verification
The hardest case to reach from the ports is a status read that lands while a channel holds only part of a result set, or holds results that the engine has not yet produced. The bench drives the engine model itself. It can stall a channel's engine so that a read burst is sure to see the not-ready state. It then releases the engine and reads again to show that the invalid burst consumed nothing. The same stall lets the bench fill an input FIFO past its depth, which is how the overflow flag and the full output FIFO are reached. Random traffic over all channels then mixes complete and partial result sets.

// File: rtl/copro_mb_pkg.sv
package copro_mb_pkg;

  // kind of word the registered read path returns
  typedef enum logic [1:0] {
    RD_ZERO   = 2'd0,
    RD_STATUS = 2'd1,
    RD_RESULT = 2'd2,
    RD_OVF    = 2'd3
  } rdKind_e;

  // strobes from the control decode to the datapath
  typedef struct packed {
    logic    push;    // accept host word into addressed input FIFO
    logic    ovfSet;  // host word dropped on a full input FIFO
    logic    pop;     // remove one result from addressed output FIFO
    logic    rdFire;  // a read strobe is being served this cycle
    rdKind_e rdKind;
  } ctrlStrb_t;

endpackage

// File: rtl/copro_mb_fifo.sv
module copro_mb_fifo #(
  parameter int DW    = 18,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         push,
  input  logic [DW-1:0]                pushData,
  input  logic                         pop,
  output logic [DW-1:0]                headData,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic          doPush, doPop;

  function automatic logic [AW-1:0] bumpPtr(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign full     = (count == CW'(DEPTH));
  assign doPush   = push && !full;
  assign doPop    = pop && (count != '0);
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= bumpPtr(wrPtr);
      if (doPop)  rdPtr <= bumpPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/copro_mb_ctrl.sv
module copro_mb_ctrl
  import copro_mb_pkg::*;
#(
  parameter int NP        = 4,
  parameter int RES_WORDS = 2,
  parameter int PW        = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [PW-1:0] hostAddr,
  input  logic          wrStrobeN,
  input  logic [1:0]    byteEn,
  input  logic          rdStrobeN,
  input  logic [NP-1:0] mbValid,
  input  logic [NP-1:0] inFull,
  output ctrlStrb_t     strb
);
  localparam int IW = $clog2(RES_WORDS + 2);
  localparam logic [PW-1:0] OVF_ADDR = PW'(NP);
  localparam logic [IW-1:0] LAST_IDX = IW'(RES_WORDS);
  localparam logic [IW-1:0] SAT_IDX  = IW'(RES_WORDS + 1);

  logic          portHit, fullSel, mbSel, wrHit, rdAct, contin;
  logic          prevRd, servQ, servNow;
  logic [PW-1:0] prevAddr;
  logic [IW-1:0] idxQ, idxNow;

  assign portHit = hostAddr < OVF_ADDR;

  always_comb begin
    fullSel = 1'b0;
    mbSel   = 1'b0;
    for (int i = 0; i < NP; i++) begin
      if (hostAddr == PW'(i)) begin
        fullSel = inFull[i];
        mbSel   = mbValid[i];
      end
    end
  end

  assign wrHit  = !wrStrobeN && (|byteEn) && portHit;
  assign rdAct  = !rdStrobeN;
  // a burst continues while the strobe stays low on the same address
  assign contin = prevRd && (prevAddr == hostAddr);

  always_comb begin
    if (!contin)              idxNow = '0;
    else if (idxQ == SAT_IDX) idxNow = SAT_IDX;
    else                      idxNow = idxQ + 1'b1;
  end

  assign servNow = (idxNow == '0) ? mbSel : servQ;

  always_comb begin
    strb.push   = wrHit && !fullSel;
    strb.ovfSet = wrHit && fullSel;
    strb.rdFire = rdAct;
    strb.pop    = 1'b0;
    strb.rdKind = RD_ZERO;
    if (rdAct) begin
      if (hostAddr == OVF_ADDR) begin
        strb.rdKind = RD_OVF;
      end else if (portHit) begin
        if (idxNow == '0) begin
          strb.rdKind = RD_STATUS;
        end else if (servNow && (idxNow <= LAST_IDX)) begin
          strb.rdKind = RD_RESULT;
          strb.pop    = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevRd   <= 1'b0;
      prevAddr <= '0;
      idxQ     <= '0;
      servQ    <= 1'b0;
    end else begin
      prevRd   <= rdAct;
      prevAddr <= hostAddr;
      if (rdAct) begin
        idxQ  <= idxNow;
        servQ <= servNow;
      end
    end
  end
endmodule

// File: rtl/copro_mb_datapath.sv
module copro_mb_datapath
  import copro_mb_pkg::*;
#(
  parameter int NP        = 4,
  parameter int DW        = 18,
  parameter int IN_DEPTH  = 8,
  parameter int OUT_DEPTH = 8,
  parameter int RES_WORDS = 2,
  parameter int PW        = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic [PW-1:0]    hostAddr,
  input  logic [DW-1:0]    wrData,
  input  logic [1:0]       byteEn,
  input  logic [NP-1:0]    engParamPop,
  input  logic [NP-1:0]    engResultPush,
  input  logic [NP*DW-1:0] engResultData,
  output logic [DW-1:0]    rdData,
  output logic             rdValid,
  output logic [NP-1:0]    mbValid,
  output logic [NP-1:0]    inFull,
  output logic [NP-1:0]    outEmpty,
  output logic [NP-1:0]    ovfFlags,
  output logic [NP-1:0]    engParamAvail,
  output logic [NP*DW-1:0] engParamData,
  output logic [NP-1:0]    engResultRoom
);
  localparam int LO_W = DW / 2;
  localparam int HI_W = DW - LO_W;
  localparam int ICW  = $clog2(IN_DEPTH + 1);
  localparam int OCW  = $clog2(OUT_DEPTH + 1);

  logic [DW-1:0] wrWord, headSel;
  logic          mbSel;
  logic [DW-1:0] outHead [NP];

  assign wrWord = {{HI_W{byteEn[1]}} & wrData[DW-1:LO_W],
                   {LO_W{byteEn[0]}} & wrData[LO_W-1:0]};

  for (genvar i = 0; i < NP; i++) begin : g_port
    localparam logic [PW-1:0] PID = PW'(i);
    logic [ICW-1:0] inCnt;
    logic [OCW-1:0] outCnt;
    logic           outFull;
    logic           ovfQ;

    copro_mb_fifo #(.DW(DW), .DEPTH(IN_DEPTH)) u_inFifo (
      .clk      (clk),
      .rstN     (rstN),
      .push     (strb.push && (hostAddr == PID)),
      .pushData (wrWord),
      .pop      (engParamPop[i]),
      .headData (engParamData[i*DW +: DW]),
      .count    (inCnt),
      .full     (inFull[i])
    );

    copro_mb_fifo #(.DW(DW), .DEPTH(OUT_DEPTH)) u_outFifo (
      .clk      (clk),
      .rstN     (rstN),
      .push     (engResultPush[i]),
      .pushData (engResultData[i*DW +: DW]),
      .pop      (strb.pop && (hostAddr == PID)),
      .headData (outHead[i]),
      .count    (outCnt),
      .full     (outFull)
    );

    always_ff @(posedge clk) begin
      if (!rstN)                                  ovfQ <= 1'b0;
      else if (strb.ovfSet && (hostAddr == PID))  ovfQ <= 1'b1;
    end

    assign engParamAvail[i] = (inCnt != '0);
    assign engResultRoom[i] = !outFull;
    assign outEmpty[i]      = (outCnt == '0);
    assign mbValid[i]       = (outCnt >= OCW'(RES_WORDS));
    assign ovfFlags[i]      = ovfQ;
  end

  always_comb begin
    headSel = '0;
    mbSel   = 1'b0;
    for (int i = 0; i < NP; i++) begin
      if (hostAddr == PW'(i)) begin
        headSel = outHead[i];
        mbSel   = mbValid[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strb.rdFire;
      if (!strb.rdFire) begin
        rdData <= '0;
      end else begin
        case (strb.rdKind)
          RD_STATUS: rdData <= {{(DW-1){1'b0}}, mbSel};
          RD_RESULT: rdData <= headSel;
          RD_OVF:    rdData <= DW'(ovfFlags);
          default:   rdData <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/copro_mailbox.sv
module copro_mailbox
  import copro_mb_pkg::*;
#(
  parameter int NP        = 4,
  parameter int DW        = 18,
  parameter int IN_DEPTH  = 8,
  parameter int OUT_DEPTH = 8,
  parameter int RES_WORDS = 2,
  localparam int PW       = $clog2(NP + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PW-1:0]    hostAddr,
  input  logic             wrStrobeN,
  input  logic [1:0]       byteEn,
  input  logic [DW-1:0]    wrData,
  input  logic             rdStrobeN,
  output logic [DW-1:0]    rdData,
  output logic             rdValid,
  output logic [NP-1:0]    engParamAvail,
  output logic [NP*DW-1:0] engParamData,
  input  logic [NP-1:0]    engParamPop,
  input  logic [NP-1:0]    engResultPush,
  input  logic [NP*DW-1:0] engResultData,
  output logic [NP-1:0]    engResultRoom
);
  ctrlStrb_t     strb;
  logic [NP-1:0] mbValid, inFull, outEmpty, ovfFlags;

  copro_mb_ctrl #(.NP(NP), .RES_WORDS(RES_WORDS), .PW(PW)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostAddr  (hostAddr),
    .wrStrobeN (wrStrobeN),
    .byteEn    (byteEn),
    .rdStrobeN (rdStrobeN),
    .mbValid   (mbValid),
    .inFull    (inFull),
    .strb      (strb)
  );

  copro_mb_datapath #(
    .NP(NP), .DW(DW), .IN_DEPTH(IN_DEPTH), .OUT_DEPTH(OUT_DEPTH),
    .RES_WORDS(RES_WORDS), .PW(PW)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .hostAddr      (hostAddr),
    .wrData        (wrData),
    .byteEn        (byteEn),
    .engParamPop   (engParamPop),
    .engResultPush (engResultPush),
    .engResultData (engResultData),
    .rdData        (rdData),
    .rdValid       (rdValid),
    .mbValid       (mbValid),
    .inFull        (inFull),
    .outEmpty      (outEmpty),
    .ovfFlags      (ovfFlags),
    .engParamAvail (engParamAvail),
    .engParamData  (engParamData),
    .engResultRoom (engResultRoom)
  );
endmodule

// File: rtl/copro_mailbox_chk.sv
module copro_mailbox_chk #(
  parameter int NP = 4,
  parameter int DW = 18,
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rstN,
  input logic [PW-1:0] hostAddr,
  input logic          wrStrobeN,
  input logic [1:0]    byteEn,
  input logic          rdStrobeN,
  input logic [DW-1:0] rdData,
  input logic          rdValid,
  input logic [NP-1:0] mbValid,
  input logic [NP-1:0] inFull,
  input logic [NP-1:0] outEmpty,
  input logic [NP-1:0] ovfFlags,
  input logic          popNow
);
  logic [NP-1:0] hitVec, selVec;

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      selVec[i] = (hostAddr == PW'(i));
      hitVec[i] = !wrStrobeN && (|byteEn) && selVec[i] && inFull[i];
    end
  end

  // R8: every read strobe yields a valid word on the next cycle
  p_rd_latency_r8: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobeN |=> rdValid);

  // R8: read data rests at zero outside valid cycles
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (rdData == '0));

  // R3: overflow flags never fall outside reset
  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((ovfFlags & $past(ovfFlags)) == $past(ovfFlags)));

  // R3: a write to a full input FIFO raises that channel's flag
  p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    (|hitVec) |=> ((ovfFlags & $past(hitVec)) == $past(hitVec)));

  // R6: results are only removed from a non-empty output FIFO
  p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (!rstN)
    popNow |-> (|(selVec & ~outEmpty)));

  // R9: leaving reset, no status or overflow bit is set
  p_reset_clear_r9: assert property (@(posedge clk)
    $rose(rstN) |-> ((mbValid == '0) && (ovfFlags == '0)));
endmodule

bind copro_mailbox copro_mailbox_chk #(.NP(NP), .DW(DW), .PW(PW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .hostAddr  (hostAddr),
  .wrStrobeN (wrStrobeN),
  .byteEn    (byteEn),
  .rdStrobeN (rdStrobeN),
  .rdData    (rdData),
  .rdValid   (rdValid),
  .mbValid   (mbValid),
  .inFull    (inFull),
  .outEmpty  (outEmpty),
  .ovfFlags  (ovfFlags),
  .popNow    (strb.pop)
);

// File: tb/copro_mailbox_test.sv
module copro_mailbox_test;
  localparam int NP = 4, DW = 18, IN_DEPTH = 8, OUT_DEPTH = 8, RES_WORDS = 2;
  localparam int PW = $clog2(NP + 1);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rstN, wrStrobeN, rdStrobeN, rdValid;
  logic [PW-1:0]    hostAddr;
  logic [1:0]       byteEn;
  logic [DW-1:0]    wrData, rdData;
  logic [NP-1:0]    engParamAvail, engParamPop, engResultPush, engResultRoom;
  logic [NP*DW-1:0] engParamData, engResultData;

  copro_mailbox #(.NP(NP), .DW(DW), .IN_DEPTH(IN_DEPTH), .OUT_DEPTH(OUT_DEPTH),
                  .RES_WORDS(RES_WORDS)) uut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .wrStrobeN(wrStrobeN),
    .byteEn(byteEn), .wrData(wrData), .rdStrobeN(rdStrobeN), .rdData(rdData),
    .rdValid(rdValid), .engParamAvail(engParamAvail), .engParamData(engParamData),
    .engParamPop(engParamPop), .engResultPush(engResultPush),
    .engResultData(engResultData), .engResultRoom(engResultRoom));

  function automatic logic [DW-1:0] xform(input logic [DW-1:0] x);
    return x ^ 18'h2D2D3;
  endfunction

  function automatic logic [DW-1:0] laneMask(input logic [DW-1:0] d, input logic [1:0] be);
    return {be[1] ? d[17:9] : 9'd0, be[0] ? d[8:0] : 9'd0};
  endfunction

  // stub echo engine: transforms each parameter word into one result word
  logic [NP-1:0] go, stall;
  logic          engineHold;
  assign engParamPop   = engParamAvail & engResultRoom & go & ~stall & {NP{~engineHold}};
  assign engResultPush = engParamPop;
  always_comb
    for (int i = 0; i < NP; i++)
      engResultData[i*DW +: DW] = xform(engParamData[i*DW +: DW]);

  always @(negedge clk) go = NP'($urandom);

  int pushCnt [NP];
  int hostPop [NP];
  always @(posedge clk) begin
    for (int i = 0; i < NP; i++) begin
      if (!rstN) pushCnt[i] = 0;
      else if (engResultPush[i]) pushCnt[i] = pushCnt[i] + 1;
    end
  end

  logic [DW-1:0] expQ [NP][$];
  logic [DW-1:0] rw [16];
  logic          rv [16];
  int            snapOcc [NP];
  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeBurst(input int p, input int n, input logic [1:0] be);
    for (int k = 0; k < n; k++) begin
      logic [DW-1:0] d;
      @(negedge clk);
      d = DW'($urandom);
      hostAddr = PW'(p); wrData = d; byteEn = be; wrStrobeN = 1'b0;
      if (p < NP && be != 2'b00 && expQ[p].size() < IN_DEPTH)
        expQ[p].push_back(xform(laneMask(d, be)));
    end
    @(negedge clk) wrStrobeN = 1'b1;
  endtask

  task automatic readWords(input int a, input int n);
    @(negedge clk);
    engineHold = 1'b1; hostAddr = PW'(a); rdStrobeN = 1'b0;
    for (int q = 0; q < NP; q++) snapOcc[q] = pushCnt[q] - hostPop[q];
    for (int j = 0; j < n; j++) begin
      @(posedge clk); @(negedge clk);
      rw[j] = rdData; rv[j] = rdValid;
      if (j == n - 1) rdStrobeN = 1'b1;
    end
    @(posedge clk); @(negedge clk);
    chk(rdValid == 1'b0 && rdData == '0, "R8 idle after burst", {rdValid, 13'd0, rdData}, 32'd0);
    engineHold = 1'b0;
  endtask

  task automatic portRead(input int p);
    bit expMb;
    readWords(p, RES_WORDS + 2);
    expMb = snapOcc[p] >= RES_WORDS;
    chk(rv[0] == 1'b1, "R8 valid after strobe", 32'(rv[0]), 32'd1);
    chk(rw[0] == {{(DW-1){1'b0}}, expMb}, "R4 status word", 32'(rw[0]), 32'(expMb));
    if (expMb) begin
      for (int j = 1; j <= RES_WORDS; j++) begin
        logic [DW-1:0] e;
        e = expQ[p].pop_front();
        chk(rw[j] == e, "R6 R11 result word", 32'(rw[j]), 32'(e));
      end
      hostPop[p] += RES_WORDS;
      chk(rw[RES_WORDS+1] == '0, "R6 word past results", 32'(rw[RES_WORDS+1]), 32'd0);
    end else begin
      for (int j = 1; j < RES_WORDS + 2; j++)
        chk(rw[j] == '0, "R5 invalid burst zeros", 32'(rw[j]), 32'd0);
    end
  endtask

  task automatic ovfRead(input logic [NP-1:0] e, input string req);
    readWords(NP, 1);
    chk(rw[0] == DW'(e), req, 32'(rw[0]), 32'(e));
  endtask

  task automatic doReset();
    @(negedge clk) rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int q = 0; q < NP; q++) begin
      expQ[q].delete();
      hostPop[q] = 0;
    end
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd7331);
    rstN = 1'b0; wrStrobeN = 1'b1; rdStrobeN = 1'b1; hostAddr = '0;
    byteEn = 2'b00; wrData = '0; stall = '0; engineHold = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    chk(rdValid == 1'b0 && rdData == '0, "R9 outputs after reset", 32'(rdData), 32'd0);
    chk(engResultRoom == '1, "R9 R10 room after reset", 32'(engResultRoom), 32'hF);

    // fill channel 0 past its depth, then reset clears everything
    stall[0] = 1'b1;
    writeBurst(0, IN_DEPTH + 1, 2'b11);
    chk(engParamAvail[0] == 1'b1, "R10 avail with queued words", 32'(engParamAvail), 32'd1);
    ovfRead(4'b0001, "R3 overflow flag ch0");
    doReset();
    stall[0] = 1'b0;
    repeat (20) @(negedge clk);
    chk(engParamAvail == '0, "R9 input FIFOs empty", 32'(engParamAvail), 32'd0);
    ovfRead('0, "R9 overflow cleared");
    portRead(0);

    // R5: status read while the engine is stalled consumes nothing
    stall[1] = 1'b1;
    writeBurst(1, RES_WORDS, 2'b11);
    portRead(1);
    chk(rw[0] == '0, "R5 not ready", 32'(rw[0]), 32'd0);
    stall[1] = 1'b0;
    repeat (40) @(negedge clk);
    portRead(1);
    chk(rw[0] == 18'd1, "R4 ready after engine", 32'(rw[0]), 32'd1);
    portRead(1);
    chk(rw[0] == '0, "R7 mailbox cleared", 32'(rw[0]), 32'd0);

    // R2: ignored writes
    writeBurst(2, 3, 2'b00);
    writeBurst(NP, 2, 2'b11);
    writeBurst(7, 2, 2'b11);
    repeat (30) @(negedge clk);
    chk(engParamAvail == '0, "R2 nothing queued", 32'(engParamAvail), 32'd0);
    portRead(2);
    ovfRead('0, "R2 flags untouched");

    // R1: byte lanes
    writeBurst(3, 2, 2'b01);
    writeBurst(3, 2, 2'b10);
    repeat (40) @(negedge clk);
    portRead(3);
    portRead(3);

    // R3 / R10: overflow on channel 2, then full output FIFO
    stall[2] = 1'b1;
    writeBurst(2, IN_DEPTH + 2, 2'b11);
    ovfRead(4'b0100, "R3 overflow flag ch2");
    stall[2] = 1'b0;
    repeat (80) @(negedge clk);
    chk(engResultRoom[2] == 1'b0, "R10 output full", 32'(engResultRoom), 32'hB);
    chk(engParamAvail[2] == 1'b0, "R10 input drained", 32'(engParamAvail), 32'd0);
    for (int k = 0; k < OUT_DEPTH / RES_WORDS; k++) portRead(2);
    ovfRead(4'b0100, "R3 flag sticky");

    // random traffic on all channels
    for (int it = 0; it < 400; it++) begin
      int op, p, room, n;
      logic [1:0] be;
      op = int'($urandom % 10);
      p  = int'($urandom % NP);
      if (op < 4) begin
        room = IN_DEPTH - expQ[p].size();
        if (room > 0) begin
          n = 1 + int'($urandom % ((room < 4) ? room : 4));
          case ($urandom % 8)
            0: be = 2'b00;
            1: be = 2'b01;
            2: be = 2'b10;
            default: be = 2'b11;
          endcase
          writeBurst(p, n, be);
        end
      end else if (op < 8) begin
        portRead(p);
      end else if (op == 8) begin
        writeBurst(NP + 1 + int'($urandom % 3), 1, 2'b11);
      end else begin
        repeat (1 + $urandom % 5) @(negedge clk);
      end
    end

    repeat (60) @(negedge clk);
    for (int p = 0; p < NP; p++)
      for (int k = 0; k < IN_DEPTH / RES_WORDS + 1; k++) portRead(p);
    ovfRead(4'b0100, "R3 R11 flags after traffic");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule